// File: doc/BRIEF.md
# Time-of-Day Clock with Sequenced Word Access

This block keeps a running time of day as a 32-bit seconds count and a 30-bit nanoseconds count that rolls over at one billion. It runs from a 125 MHz reference, so without trim it adds 8 ns on every clock. A signed fractional trim nudges the rate: a 26-bit rate value is summed into a 32-bit fraction of a nanosecond each cycle, and each carry out of that fraction adds or removes one nanosecond.

Software reaches the block through a small 16-bit register interface with four addresses. A single data address is accessed four times in a fixed order to move a full time value. Writes to it stage a value for a later load (replace the time) or step (add a signed offset) command. Reads from it return a snapshot that a read command captured. Two rate addresses hold the trim magnitude and direction. The rate takes effect when its low half is written.

Top module: `ptp_tod_clock`

## Requirements
- R1: While reset is held, tod_sec, tod_ns and rdata are all zero.
- R2: Address 0 is control, 1 is data, 2 is rate high and 3 is rate low. Successive data writes fill the staging words in the order ns[15:0], ns[31:16], sec[15:0], sec[31:16], and the index wraps after four. Any control write returns the staging index to the first word.
- R3: With a zero rate, tod_ns grows by 8 every cycle. A result of 1,000,000,000 or more has that amount subtracted and adds one to tod_sec, which wraps modulo 2^32. tod_ns never reaches 1,000,000,000.
- R4: A control write with bit 0 set (load) makes the time, one cycle later, equal to the staged value: ns from staged bits [29:0] and sec from the two upper words. Load wins when bit 1 is also set.
- R5: A control write with bit 1 set (step) and bit 0 clear adds the staged value to the current time. The staged ns is a signed 32-bit offset with magnitude below 1,000,000,000 and the staged sec is a signed 32-bit offset. The result is normalised so that a negative ns borrows one second and an ns of one billion or more carries one. The nominal increment is not added on that cycle.
- R6: A control write with bit 2 set captures the time as it stands before that edge and rewinds the read index. The next four data reads return ns[15:0], {2'b00, ns[29:16]}, sec[15:0] and sec[31:16], each appearing on rdata in the cycle after the read strobe.
- R7: Rate high holds the direction in bit 15 (1 = slow) and rate bits [25:16] in bits [9:0]. A rate-low write commits rate = {high[9:0], low} with the stored direction. From the next cycle each fraction carry adds 1 ns when fast, or removes 1 ns when slow, on top of the 8 ns.
- R8: A read strobe at any address other than data returns zero on rdata and leaves the read index where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock |
| rst_n | input | 1 | synchronous active-low reset |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe |
| addr | input | 2 | register address |
| wdata | input | 16 | write data |
| rdata | output | 16 | read data, registered |
| tod_sec | output | 32 | current seconds |
| tod_ns | output | 30 | current nanoseconds |

## Verification
Directed patterns aim at the rollover edges. A load just below one second separates correct carry from a missed one. A negative step taken while ns is small shows whether the borrow works, and a near-one-second positive step shows whether the carry works. A load and a step written together show which one wins. A stale partial staging sequence shows whether a control write rewinds the index. A snapshot read broken up by a read of another address shows that the read index is unaffected. Random loads, steps, rate trims in both directions and idle stretches are then compared against a cycle model, which tells fraction carry timing and direction apart from a plain 8 ns count.

// File: rtl/ptpc_pkg.sv
// Shared register map and command encoding for the time-of-day clock.
// Assumes a 2-bit register address space with four registers.
package ptpc_pkg;

    typedef enum logic [1:0] {
        REG_CTRL    = 2'd0,
        REG_DATA    = 2'd1,
        REG_RATE_HI = 2'd2,
        REG_RATE_LO = 2'd3
    } ptpc_addr_e;

    localparam int CMD_LOAD_BIT = 0;
    localparam int CMD_STEP_BIT = 1;
    localparam int CMD_SNAP_BIT = 2;
    localparam int RATE_DIR_BIT = 15;
    localparam int STAGE_WORDS  = 4;

    typedef struct packed {
        logic load;
        logic step;
        logic snap;
    } ptpc_cmd_t;

endpackage

// File: rtl/ptpc_regif.sv
// Register front end: decodes control commands, stages four data words,
// holds the snapshot and its read index, and keeps the rate registers.
// Assumes reads and snapshot commands are not issued in the same cycle.
module ptpc_regif
    import ptpc_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int NS_W   = 30,
    parameter int SEC_W  = 32,
    parameter int RATE_W = 26
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [1:0]          addr,
    input  logic [REG_W-1:0]    wdata,
    input  logic [NS_W-1:0]     tod_ns,
    input  logic [SEC_W-1:0]    tod_sec,
    output ptpc_cmd_t           cmd,
    output logic [2*REG_W-1:0]  stg_ns,
    output logic [SEC_W-1:0]    stg_sec,
    output logic [RATE_W-1:0]   rate_val,
    output logic                rate_slow,
    output logic [REG_W-1:0]    rdata
);
    localparam int PTR_W     = $clog2(STAGE_WORDS);
    localparam int RATE_HI_W = RATE_W - REG_W;
    localparam int SNAP_W    = STAGE_WORDS * REG_W;
    localparam int NS_PAD    = 2 * REG_W - NS_W;

    logic                 ctrl_wr, data_wr, data_rd;
    logic [PTR_W-1:0]     wptr_q, rptr_q;
    logic [SNAP_W-1:0]    stage_flat;
    logic [NS_W-1:0]      snap_ns_q;
    logic [SEC_W-1:0]     snap_sec_q;
    logic [SNAP_W-1:0]    snap_flat;
    logic                 hi_dir_q;
    logic [RATE_HI_W-1:0] hi_bits_q;

    assign ctrl_wr = wr_en && (addr == REG_CTRL);
    assign data_wr = wr_en && (addr == REG_DATA);
    assign data_rd = rd_en && (addr == REG_DATA);

    assign cmd.load = ctrl_wr && wdata[CMD_LOAD_BIT];
    assign cmd.step = ctrl_wr && wdata[CMD_STEP_BIT];
    assign cmd.snap = ctrl_wr && wdata[CMD_SNAP_BIT];

    // Staging write index: rewinds on control write, advances on data write.
    always_ff @(posedge clk) begin
        if (!rst_n)       wptr_q <= '0;
        else if (ctrl_wr) wptr_q <= '0;
        else if (data_wr) wptr_q <= wptr_q + 1'b1;
    end

    // One staging word per slot, each loaded when the index points at it.
    for (genvar i = 0; i < STAGE_WORDS; i++) begin : g_stage
        logic [REG_W-1:0] word_q;
        // Capture write data into this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  word_q <= '0;
            else if (data_wr && wptr_q == PTR_W'(i))     word_q <= wdata;
        end
        assign stage_flat[i*REG_W +: REG_W] = word_q;
    end

    assign stg_ns  = stage_flat[0 +: 2*REG_W];
    assign stg_sec = stage_flat[2*REG_W +: SEC_W];

    // Snapshot capture of the current time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_ns_q  <= '0;
            snap_sec_q <= '0;
        end else if (cmd.snap) begin
            snap_ns_q  <= tod_ns;
            snap_sec_q <= tod_sec;
        end
    end

    // Read index: rewinds on snapshot, advances on data read.
    always_ff @(posedge clk) begin
        if (!rst_n)        rptr_q <= '0;
        else if (cmd.snap) rptr_q <= '0;
        else if (data_rd)  rptr_q <= rptr_q + 1'b1;
    end

    assign snap_flat = {snap_sec_q, {NS_PAD{1'b0}}, snap_ns_q};

    // Registered read data: snapshot word for data reads, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (data_rd) rdata <= snap_flat[rptr_q*REG_W +: REG_W];
        else if (rd_en)   rdata <= '0;
    end

    // Rate high half: holds direction and upper rate bits until commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_dir_q  <= 1'b0;
            hi_bits_q <= '0;
        end else if (wr_en && addr == REG_RATE_HI) begin
            hi_dir_q  <= wdata[RATE_DIR_BIT];
            hi_bits_q <= wdata[RATE_HI_W-1:0];
        end
    end

    // Rate commit on the low-half write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_val  <= '0;
            rate_slow <= 1'b0;
        end else if (wr_en && addr == REG_RATE_LO) begin
            rate_val  <= {hi_bits_q, wdata};
            rate_slow <= hi_dir_q;
        end
    end

endmodule

// File: rtl/ptpc_rate.sv
// Fractional rate accumulator: adds the rate value to a fraction of a
// nanosecond every cycle and flags a carry as a +1 or -1 ns correction.
// Assumes RATE_W is below FRAC_W so at most one carry occurs per cycle.
module ptpc_rate #(
    parameter int FRAC_W = 32,
    parameter int RATE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_val,
    input  logic              rate_slow,
    output logic              adj_up,
    output logic              adj_down
);
    logic [FRAC_W-1:0] frac_q;
    logic [FRAC_W:0]   frac_sum;

    assign frac_sum = {1'b0, frac_q} + (FRAC_W+1)'(rate_val);
    assign adj_up   = frac_sum[FRAC_W] && !rate_slow;
    assign adj_down = frac_sum[FRAC_W] &&  rate_slow;

    // Fraction register keeps the remainder below one nanosecond.
    always_ff @(posedge clk) begin
        if (!rst_n) frac_q <= '0;
        else        frac_q <= frac_sum[FRAC_W-1:0];
    end

endmodule

// File: rtl/ptpc_tod.sv
// Seconds and nanoseconds counter with load, signed step and trimmed tick.
// Assumes loaded ns is below NS_PER_SEC and step ns offset magnitude is too.
module ptpc_tod #(
    parameter int NS_W       = 30,
    parameter int SEC_W      = 32,
    parameter int OFF_W      = 32,
    parameter int NOM_INC    = 8,
    parameter int NS_PER_SEC = 1000000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_load,
    input  logic              do_step,
    input  logic [OFF_W-1:0]  stg_ns,
    input  logic [SEC_W-1:0]  stg_sec,
    input  logic              adj_up,
    input  logic              adj_down,
    output logic [NS_W-1:0]   ns_q,
    output logic [SEC_W-1:0]  sec_q
);
    localparam int SW = OFF_W + 2;
    localparam logic [NS_W:0]        NSP = (NS_W+1)'(NS_PER_SEC);
    localparam logic signed [SW-1:0] NSS = SW'(NS_PER_SEC);

    logic [NS_W:0]        inc, ns_tick;
    logic signed [SW-1:0] ns_ext, off_ext, step_sum, step_norm;
    logic [SEC_W-1:0]     step_sec;
    logic [NS_W-1:0]      ns_n;
    logic [SEC_W-1:0]     sec_n;

    // Trimmed tick: nominal increment plus fraction correction, then wrap.
    always_comb begin
        inc = (NS_W+1)'(NOM_INC);
        if (adj_up)   inc = inc + 1'b1;
        if (adj_down) inc = inc - 1'b1;
        ns_tick = {1'b0, ns_q} + inc;
    end

    assign ns_ext   = {{(SW-NS_W){1'b0}}, ns_q};
    assign off_ext  = {{(SW-OFF_W){stg_ns[OFF_W-1]}}, stg_ns};
    assign step_sum = ns_ext + off_ext;

    // Step normalisation: borrow or carry one second when ns leaves range.
    always_comb begin
        step_norm = step_sum;
        step_sec  = sec_q + stg_sec;
        if (step_sum < 0) begin
            step_norm = step_sum + NSS;
            step_sec  = sec_q + stg_sec - SEC_W'(1);
        end else if (step_sum >= NSS) begin
            step_norm = step_sum - NSS;
            step_sec  = sec_q + stg_sec + SEC_W'(1);
        end
    end

    // Next-state select: load beats step, step beats tick.
    always_comb begin
        if (do_load) begin
            ns_n  = stg_ns[NS_W-1:0];
            sec_n = stg_sec;
        end else if (do_step) begin
            ns_n  = step_norm[NS_W-1:0];
            sec_n = step_sec;
        end else if (ns_tick >= NSP) begin
            ns_n  = NS_W'(ns_tick - NSP);
            sec_n = sec_q + SEC_W'(1);
        end else begin
            ns_n  = ns_tick[NS_W-1:0];
            sec_n = sec_q;
        end
    end

    // Time registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ns_q  <= '0;
            sec_q <= '0;
        end else begin
            ns_q  <= ns_n;
            sec_q <= sec_n;
        end
    end

endmodule

// File: rtl/ptp_tod_clock.sv
// Top of the time-of-day clock: register front end, rate accumulator and
// time counter. Assumes a 125 MHz clock (NOM_INC_NS = 8) and 16-bit access.
module ptp_tod_clock
    import ptpc_pkg::*;
#(
    parameter int REG_W      = 16,
    parameter int NS_W       = 30,
    parameter int SEC_W      = 32,
    parameter int FRAC_W     = 32,
    parameter int RATE_W     = 26,
    parameter int NOM_INC_NS = 8,
    parameter int NS_PER_SEC = 1000000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [SEC_W-1:0] tod_sec,
    output logic [NS_W-1:0]  tod_ns
);
    localparam int OFF_W = 2 * REG_W;

    ptpc_cmd_t         cmd;
    logic [OFF_W-1:0]  stg_ns;
    logic [SEC_W-1:0]  stg_sec;
    logic [RATE_W-1:0] rate_val;
    logic              rate_slow;
    logic              adj_up, adj_down;

    ptpc_regif #(
        .REG_W(REG_W), .NS_W(NS_W), .SEC_W(SEC_W), .RATE_W(RATE_W)
    ) u_regif (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .tod_ns(tod_ns), .tod_sec(tod_sec),
        .cmd(cmd), .stg_ns(stg_ns), .stg_sec(stg_sec),
        .rate_val(rate_val), .rate_slow(rate_slow), .rdata(rdata)
    );

    ptpc_rate #(
        .FRAC_W(FRAC_W), .RATE_W(RATE_W)
    ) u_rate (
        .clk(clk), .rst_n(rst_n), .rate_val(rate_val), .rate_slow(rate_slow),
        .adj_up(adj_up), .adj_down(adj_down)
    );

    ptpc_tod #(
        .NS_W(NS_W), .SEC_W(SEC_W), .OFF_W(OFF_W),
        .NOM_INC(NOM_INC_NS), .NS_PER_SEC(NS_PER_SEC)
    ) u_tod (
        .clk(clk), .rst_n(rst_n), .do_load(cmd.load), .do_step(cmd.step),
        .stg_ns(stg_ns), .stg_sec(stg_sec), .adj_up(adj_up),
        .adj_down(adj_down), .ns_q(tod_ns), .sec_q(tod_sec)
    );

endmodule

// File: rtl/ptp_tod_clock_chk.sv
// Property checker for the time-of-day clock, bound to the top module.
module ptp_tod_clock_chk #(
    parameter int REG_W      = 16,
    parameter int NS_W       = 30,
    parameter int SEC_W      = 32,
    parameter int RATE_W     = 26,
    parameter int NS_PER_SEC = 1000000000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               rd_en,
    input logic [1:0]         addr,
    input logic [REG_W-1:0]   wdata,
    input logic [REG_W-1:0]   rdata,
    input logic [SEC_W-1:0]   tod_sec,
    input logic [NS_W-1:0]    tod_ns,
    input logic [RATE_W-1:0]  rate_val,
    input logic [2*REG_W-1:0] stg_ns,
    input logic [SEC_W-1:0]   stg_sec
);
    logic time_cmd;
    assign time_cmd = wr_en && (addr == 2'd0) && (wdata[0] || wdata[1]);

    assert_ns_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tod_ns) < NS_PER_SEC);

    assert_nominal_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!time_cmd && rate_val == '0 && int'(tod_ns) < NS_PER_SEC - 9)
        |=> (int'(tod_ns) == int'($past(tod_ns)) + 8 && $stable(tod_sec)));

    assert_second_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!time_cmd && int'(tod_ns) >= NS_PER_SEC - 7)
        |=> (tod_sec == $past(tod_sec) + 1'b1));

    assert_trim_bounds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!time_cmd && int'(tod_ns) < NS_PER_SEC - 9)
        |=> (int'(tod_ns) - int'($past(tod_ns)) >= 7 &&
             int'(tod_ns) - int'($past(tod_ns)) <= 9));

    assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0 && wdata[0])
        |=> (tod_ns == $past(stg_ns[NS_W-1:0]) && tod_sec == $past(stg_sec)));

    assert_other_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != 2'd1) |=> (rdata == '0));

endmodule

bind ptp_tod_clock ptp_tod_clock_chk #(
    .REG_W(REG_W), .NS_W(NS_W), .SEC_W(SEC_W),
    .RATE_W(RATE_W), .NS_PER_SEC(NS_PER_SEC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tod_sec(tod_sec), .tod_ns(tod_ns),
    .rate_val(rate_val), .stg_ns(stg_ns), .stg_sec(stg_sec)
);

// File: tb/ptp_tod_clock_tb.sv
module ptp_tod_clock_tb;
    localparam longint NSPS = 1000000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic [31:0] tod_sec;
    logic [29:0] tod_ns;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ptp_tod_clock u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tod_sec(tod_sec), .tod_ns(tod_ns)
    );

    // ---------------- cycle model built from the requirements ----------------
    logic [15:0] m_stage [4];
    logic [1:0]  m_wp, m_rp;
    longint      m_ns;
    logic [31:0] m_sec, m_frac, m_snap_sec;
    logic [29:0] m_snap_ns;
    logic [25:0] m_rate;
    logic        m_slow;
    logic [15:0] m_hi, m_rdata;

    always @(posedge clk) begin : model
        logic [32:0] fs;
        logic [63:0] sw;
        longint      t;
        logic [31:0] offs, offn;
        logic        ctl;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_stage[i] = 16'd0;
            m_wp = 0; m_rp = 0; m_ns = 0; m_sec = 0; m_frac = 0;
            m_snap_sec = 0; m_snap_ns = 0; m_rate = 0; m_slow = 0;
            m_hi = 0; m_rdata = 0;
        end else begin
            ctl = wr_en && addr == 2'd0;
            fs = {1'b0, m_frac} + {7'b0, m_rate};
            m_frac = fs[31:0];
            if (ctl && wdata[2]) begin m_snap_ns = m_ns[29:0]; m_snap_sec = m_sec; end
            offn = {m_stage[1], m_stage[0]};
            offs = {m_stage[3], m_stage[2]};
            if (ctl && wdata[0]) begin
                m_ns = longint'(offn[29:0]); m_sec = offs;
            end else if (ctl && wdata[1]) begin
                t = m_ns + longint'($signed(offn));
                m_sec = m_sec + offs;
                if (t < 0) begin t = t + NSPS; m_sec = m_sec - 1; end
                else if (t >= NSPS) begin t = t - NSPS; m_sec = m_sec + 1; end
                m_ns = t;
            end else begin
                t = m_ns + 8;
                if (fs[32]) t = m_slow ? t - 1 : t + 1;
                if (t >= NSPS) begin t = t - NSPS; m_sec = m_sec + 1; end
                m_ns = t;
            end
            if (rd_en) begin
                if (addr == 2'd1) begin
                    sw = {m_snap_sec, 2'b00, m_snap_ns};
                    m_rdata = sw[m_rp*16 +: 16];
                    m_rp = m_rp + 1;
                end else m_rdata = 16'd0;
            end
            if (ctl) begin m_wp = 0; if (wdata[2]) m_rp = 0; end
            if (wr_en && addr == 2'd1) begin m_stage[m_wp] = wdata; m_wp = m_wp + 1; end
            if (wr_en && addr == 2'd2) m_hi = wdata;
            if (wr_en && addr == 2'd3) begin m_rate = {m_hi[9:0], wdata}; m_slow = m_hi[15]; end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_time(input string req);
        chk(req, {tod_sec, 2'b00, tod_ns}, {m_sec, 2'b00, m_ns[29:0]});
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    // Control write that also reports the time seen just before the edge.
    task automatic cmd_obs(input logic [15:0] d, output logic [29:0] nb, output logic [31:0] sb);
        @(negedge clk); nb = tod_ns; sb = tod_sec; wr_en = 1; addr = 2'd0; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic stage(input logic [31:0] n, input logic [31:0] s);
        wr(2'd1, n[15:0]); wr(2'd1, n[31:16]); wr(2'd1, s[15:0]); wr(2'd1, s[31:16]);
    endtask

    function automatic logic [25:0] ppb_to_rate(input int unsigned p);
        longint r;
        r = (longint'(p) << 26) / 1953125;
        return r[25:0];
    endfunction

    task automatic set_rate(input int unsigned p, input logic slow);
        logic [25:0] r;
        r = ppb_to_rate(p);
        wr(2'd2, {slow, 5'd0, r[25:16]});
        wr(2'd3, r[15:0]);
    endtask

    function automatic logic [63:0] step_expect(input logic [29:0] nb, input logic [31:0] sb,
                                               input logic [31:0] on, input logic [31:0] os);
        longint t; logic [31:0] s;
        t = longint'(nb) + longint'($signed(on));
        s = sb + os;
        if (t < 0) begin t = t + NSPS; s = s - 1; end
        else if (t >= NSPS) begin t = t - NSPS; s = s + 1; end
        return {s, 2'b00, t[29:0]};
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [29:0] nb, a;
        logic [31:0] sb;
        logic [15:0] d;
        int unsigned seed;
        seed = $urandom(32'h5eed);

        idle(3);
        chk("R1 reset time", {tod_sec, 2'b00, tod_ns}, 64'd0);
        chk("R1 reset rdata", {48'd0, rdata}, 64'd0);
        rst_n = 1;

        // R3 nominal rate
        idle(1); a = tod_ns; idle(5);
        chk("R3 five ticks", {34'd0, tod_ns}, {34'd0, a + 30'd40});

        // R4 load near rollover, then R3 carry
        stage(32'd999999990, 32'd5);
        cmd_obs(16'h0001, nb, sb);
        chk("R4 load value", {tod_sec, 2'b00, tod_ns}, {32'd5, 32'd999999990});
        idle(2);
        chk("R3 second carry", {tod_sec, 2'b00, tod_ns}, {32'd6, 32'd6});

        // R5 negative step with borrow
        stage(32'd50, 32'd10);
        cmd_obs(16'h0001, nb, sb);
        stage(32'hFFFFFF38, 32'd3);
        cmd_obs(16'h0002, nb, sb);
        chk("R5 step borrow", {tod_sec, 2'b00, tod_ns}, step_expect(nb, sb, 32'hFFFFFF38, 32'd3));
        chk_time("R5 step borrow model");

        // R5 positive step with carry, negative seconds offset
        stage(32'd999999999, 32'hFFFFFFFE);
        cmd_obs(16'h0002, nb, sb);
        chk("R5 step carry", {tod_sec, 2'b00, tod_ns}, step_expect(nb, sb, 32'd999999999, 32'hFFFFFFFE));

        // R4 load beats step
        stage(32'd123456, 32'd77);
        cmd_obs(16'h0003, nb, sb);
        chk("R4 load priority", {tod_sec, 2'b00, tod_ns}, {32'd77, 32'd123456});

        // R2 control write rewinds the staging index
        wr(2'd1, 16'hAAAA); wr(2'd1, 16'hBBBB); wr(2'd0, 16'h0000);
        stage(32'd500, 32'd9);
        cmd_obs(16'h0001, nb, sb);
        chk("R2 staging rewind", {tod_sec, 2'b00, tod_ns}, {32'd9, 32'd500});

        // R2 index wraps after four words
        stage(32'd1, 32'd2); stage(32'd700, 32'd11);
        cmd_obs(16'h0001, nb, sb);
        chk("R2 staging wrap", {tod_sec, 2'b00, tod_ns}, {32'd11, 32'd700});

        // R6 snapshot read, interrupted by an R8 read elsewhere
        cmd_obs(16'h0004, nb, sb);
        rd(2'd1, d); chk("R6 word ns lo", {48'd0, d}, {48'd0, nb[15:0]});
        rd(2'd1, d); chk("R6 word ns hi", {48'd0, d}, {48'd0, 2'b00, nb[29:16]});
        rd(2'd2, d); chk("R8 other read zero", {48'd0, d}, 64'd0);
        rd(2'd1, d); chk("R6 word sec lo R8 index kept", {48'd0, d}, {48'd0, sb[15:0]});
        rd(2'd1, d); chk("R6 word sec hi", {48'd0, d}, {48'd0, sb[31:16]});

        // R7 fast and slow trim over 1000 cycles
        stage(32'd0, 32'd0); cmd_obs(16'h0001, nb, sb);
        set_rate(1953124, 1'b0);
        a = tod_ns; idle(1000);
        chk("R7 fast gains", {63'd0, (tod_ns - a) > 30'd8000}, 64'd1);
        chk_time("R7 fast model");
        stage(32'd0, 32'd0); cmd_obs(16'h0001, nb, sb);
        set_rate(1953124, 1'b1);
        a = tod_ns; idle(1000);
        chk("R7 slow loses", {63'd0, (tod_ns - a) < 30'd8000}, 64'd1);
        chk_time("R7 slow model");

        // Random mix checked against the model
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0: begin
                    stage($urandom % 32'd1000000000, $urandom);
                    wr(2'd0, 16'h0001); chk_time("R4 random load");
                end
                1: begin
                    int off;
                    off = int'($urandom % 32'd1999999999) - 999999999;
                    stage(32'(off), $urandom);
                    wr(2'd0, 16'h0002); chk_time("R5 random step");
                end
                2: begin
                    set_rate($urandom % 32'd1953125, 1'($urandom));
                    idle(int'($urandom % 200)); chk_time("R7 random trim");
                end
                3: begin
                    wr(2'd0, 16'h0004);
                    for (int w = 0; w < 4; w++) begin
                        rd(2'd1, d); chk("R6 random snapshot", {48'd0, d}, {48'd0, m_rdata});
                    end
                end
                4: begin
                    rd(2'($urandom % 2) + 2'd2, d); chk("R8 random other read", {48'd0, d}, 64'd0);
                end
                default: begin
                    idle(int'($urandom % 50)); chk_time("R3 random idle");
                end
            endcase
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule